// File: doc/BRIEF.md
# Disk Geometry Calculator

This block turns a drive's total sector count into a default cylinder, head and sectors-per-track geometry for an identify reply. The caller places a 32-bit capacity on `capacity_i` and pulses `start_i`. Some time later the block raises `done_o` for one cycle, and the three geometry outputs are valid from that cycle onward.

Very large drives receive a fixed, clamped geometry. Empty drives receive an all-zero geometry. Both answers are produced in the cycle after the start pulse. Any other capacity goes through two divisions in turn. The first, capacity by sectors-per-track, gives the head count. The second, capacity by heads times sectors, gives the cylinder count. Both divisions share one restoring divider that produces one quotient bit per clock.

Top module: `chs_geometry`

## Requirements
- R1: When the capacity is 16383*16*63 = 16514064 or more, the outputs are cylinders 16383, heads 16, sectors 63.
- R2: Below that limit, sectors-per-track is 63 when the capacity is 63 or more. Otherwise it equals the capacity.
- R3: Below that limit, heads is 16 when capacity / sectors-per-track is 16 or more. Otherwise it equals that integer quotient.
- R4: Below that limit, cylinders is capacity / (heads * sectors-per-track), truncated. It never exceeds 16383.
- R5: A capacity of zero gives cylinders 0, heads 0 and sectors 0. No division is started, so the divider never receives a zero divisor.
- R6: `done_o` is high for exactly one cycle per accepted start. For a zero or clamped capacity it is high in the cycle after the start pulse. Otherwise it rises within 80 cycles of the start pulse.
- R7: A `start_i` pulse that arrives while a calculation is running is ignored. The result still belongs to the capacity that began the calculation.
- R8: The geometry outputs change only in the cycle where `done_o` is high. They hold their values until the next result, whatever happens on `capacity_i`.
- R9: While reset is asserted and after it is released, all outputs are zero until the first result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Starts a calculation when the block is idle |
| capacity_i | input | 32 | Total sector count, sampled with start |
| cyl_o | output | 16 | Default cylinder count |
| heads_o | output | 8 | Default head count |
| spt_o | output | 8 | Default sectors per track |
| done_o | output | 1 | One-cycle pulse marking a new result |

## Verification
On every cycle, the assertions check the following:
- the width of the done pulse;
- that the outputs stay stable outside a done cycle;
- the output ranges;
- the one-cycle answers for zero and clamped capacities;
- that the divider never receives a zero divisor;
- the restoring-divider remainder invariant.

The exact arithmetic of the heads and cylinder divisions can only be shown by the bench. It compares against a reference computed arithmetically over a sweep of small capacities and around the 63, 1008 and clamp thresholds. The bench scenarios also cover start pulses that arrive mid-calculation and capacity changes while the block is idle.

// File: rtl/chs_geom_pkg.sv
// Shared types for the geometry calculator.
package chs_geom_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DIV_H = 2'd1,
        ST_DIV_C = 2'd2
    } calc_state_t;
endpackage

// File: rtl/chs_divider.sv
// Restoring unsigned divider: one quotient bit per cycle, W cycles per divide.
// Assumes the divisor is nonzero when go is asserted; fin pulses one cycle
// after the last iteration, with quot valid from then until the next go.
module chs_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quot,
    output logic         fin
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    rem_q;
    logic [W-1:0]  qreg_q;
    logic [W-1:0]  den_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    shifted;
    logic          take;
    logic [W:0]    rem_next;

    // Trial subtraction for the current quotient bit.
    always_comb begin
        shifted  = {rem_q[W-1:0], qreg_q[W-1]};
        take     = (shifted >= {1'b0, den_q});
        rem_next = take ? (shifted - {1'b0, den_q}) : shifted;
    end

    // Load operands on go, then shift one bit per cycle until the count runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            qreg_q <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                rem_q  <= '0;
                qreg_q <= dividend;
                den_q  <= divisor;
                cnt_q  <= CW'(W);
            end else if (cnt_q != '0) begin
                rem_q  <= rem_next;
                qreg_q <= {qreg_q[W-2:0], take};
                cnt_q  <= cnt_q - 1'b1;
                if (cnt_q == CW'(1))
                    fin <= 1'b1;
            end
        end
    end

    assign quot = qreg_q;

    // R5: a division is never started with a zero divisor.
    assert_nonzero_divisor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (divisor != '0));

    // R4: the remainder stays below the divisor while iterating.
    assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (rem_q < {1'b0, den_q}));
endmodule

// File: rtl/chs_clamp.sv
// Threshold logic: detects empty and oversized drives, picks sectors-per-track
// from the capacity, and clamps a quotient into a head count.
// Purely combinational; assumes the product of the limits fits in CAP_W bits.
module chs_clamp #(
    parameter int CAP_W     = 32,
    parameter int HEAD_W    = 8,
    parameter int SPT_W     = 8,
    parameter int MAX_CYL   = 16383,
    parameter int MAX_HEADS = 16,
    parameter int MAX_SPT   = 63
) (
    input  logic [CAP_W-1:0]  cap,
    input  logic [CAP_W-1:0]  quot,
    output logic              is_zero,
    output logic              is_big,
    output logic [SPT_W-1:0]  spt_sel,
    output logic [HEAD_W-1:0] heads_sel
);
    localparam logic [CAP_W-1:0] BIG_CAP  = CAP_W'(MAX_CYL * MAX_HEADS * MAX_SPT);
    localparam logic [CAP_W-1:0] SPT_CAP  = CAP_W'(MAX_SPT);
    localparam logic [CAP_W-1:0] HEAD_CAP = CAP_W'(MAX_HEADS);

    // Classify the capacity and clamp the sector and head fields.
    always_comb begin
        is_zero   = (cap == '0);
        is_big    = (cap >= BIG_CAP);
        spt_sel   = (cap >= SPT_CAP) ? SPT_W'(MAX_SPT) : cap[SPT_W-1:0];
        heads_sel = (quot >= HEAD_CAP) ? HEAD_W'(MAX_HEADS) : quot[HEAD_W-1:0];
    end
endmodule

// File: rtl/chs_geometry.sv
// Geometry calculator top: accepts a capacity on start_i when idle. It
// answers zero and clamped capacities directly; otherwise it runs a heads
// division and then a cylinder division on one shared divider.
// Assumes the limits below make the clamp threshold fit in CAP_W bits.
module chs_geometry
    import chs_geom_pkg::*;
#(
    parameter int CAP_W     = 32,
    parameter int CYL_W     = 16,
    parameter int HEAD_W    = 8,
    parameter int SPT_W     = 8,
    parameter int MAX_CYL   = 16383,
    parameter int MAX_HEADS = 16,
    parameter int MAX_SPT   = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CAP_W-1:0]  capacity_i,
    output logic [CYL_W-1:0]  cyl_o,
    output logic [HEAD_W-1:0] heads_o,
    output logic [SPT_W-1:0]  spt_o,
    output logic              done_o
);
    calc_state_t       state_q;
    logic [CAP_W-1:0]  cap_q;
    logic [SPT_W-1:0]  spt_q;
    logic [HEAD_W-1:0] heads_q;
    logic              div_go;
    logic [CAP_W-1:0]  div_den;
    logic [CAP_W-1:0]  div_quot;
    logic              div_fin;
    logic              is_zero, is_big;
    logic [SPT_W-1:0]  spt_sel;
    logic [HEAD_W-1:0] heads_sel;

    chs_clamp #(
        .CAP_W(CAP_W), .HEAD_W(HEAD_W), .SPT_W(SPT_W),
        .MAX_CYL(MAX_CYL), .MAX_HEADS(MAX_HEADS), .MAX_SPT(MAX_SPT)
    ) clamp_i (
        .cap(capacity_i), .quot(div_quot),
        .is_zero(is_zero), .is_big(is_big),
        .spt_sel(spt_sel), .heads_sel(heads_sel)
    );

    chs_divider #(.W(CAP_W)) div_i (
        .clk(clk), .rst_n(rst_n), .go(div_go),
        .dividend(cap_q), .divisor(div_den),
        .quot(div_quot), .fin(div_fin)
    );

    // Sequence the calculation and publish the result with a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cap_q   <= '0;
            spt_q   <= '0;
            heads_q <= '0;
            div_go  <= 1'b0;
            div_den <= '0;
            cyl_o   <= '0;
            heads_o <= '0;
            spt_o   <= '0;
            done_o  <= 1'b0;
        end else begin
            div_go <= 1'b0;
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cap_q <= capacity_i;
                        if (is_zero) begin
                            cyl_o   <= '0;
                            heads_o <= '0;
                            spt_o   <= '0;
                            done_o  <= 1'b1;
                        end else if (is_big) begin
                            cyl_o   <= CYL_W'(MAX_CYL);
                            heads_o <= HEAD_W'(MAX_HEADS);
                            spt_o   <= SPT_W'(MAX_SPT);
                            done_o  <= 1'b1;
                        end else begin
                            spt_q   <= spt_sel;
                            div_den <= CAP_W'(spt_sel);
                            div_go  <= 1'b1;
                            state_q <= ST_DIV_H;
                        end
                    end
                end
                ST_DIV_H: begin
                    if (div_fin) begin
                        heads_q <= heads_sel;
                        div_den <= CAP_W'(heads_sel) * CAP_W'(spt_q);
                        div_go  <= 1'b1;
                        state_q <= ST_DIV_C;
                    end
                end
                ST_DIV_C: begin
                    if (div_fin) begin
                        cyl_o   <= div_quot[CYL_W-1:0];
                        heads_o <= heads_q;
                        spt_o   <= spt_q;
                        done_o  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R6: done lasts one cycle.
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: outputs move only together with done.
    assert_hold_cyl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(cyl_o));
    assert_hold_heads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(heads_o));
    assert_hold_spt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(spt_o));

    // R2, R3: published fields never exceed their limits.
    assert_spt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (spt_o <= SPT_W'(MAX_SPT)));
    assert_heads_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (heads_o <= HEAD_W'(MAX_HEADS)));

    // R4: the cylinder quotient fits its field and the limit.
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIV_C && div_fin) |->
            (div_quot[CAP_W-1:CYL_W] == '0 && div_quot[CYL_W-1:0] <= CYL_W'(MAX_CYL)));

    // R5: an empty drive answers zeros in the next cycle.
    assert_zero_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && capacity_i == '0) |=>
            (done_o && cyl_o == '0 && heads_o == '0 && spt_o == '0));

    // R1: an oversized drive answers the clamped geometry in the next cycle.
    assert_big_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && is_big) |=>
            (done_o && cyl_o == CYL_W'(MAX_CYL) && heads_o == HEAD_W'(MAX_HEADS)
             && spt_o == SPT_W'(MAX_SPT)));

    // R7: a start during a calculation does not replace the captured capacity.
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (cap_q == $past(cap_q)));
endmodule

// File: tb/chs_geometry_tb_top.sv
// Sweep bench: compares every result against arithmetic computed here.
module chs_geometry_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] capacity_i = '0;
    logic [15:0] cyl_o;
    logic [7:0]  heads_o;
    logic [7:0]  spt_o;
    logic        done_o;

    int total = 0;
    int bad = 0;

    localparam longint BIG = 64'd16383 * 16 * 63;

    always #10 clk = ~clk;

    chs_geometry dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .capacity_i(capacity_i),
        .cyl_o(cyl_o), .heads_o(heads_o), .spt_o(spt_o), .done_o(done_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void geom(input longint cap, output longint c,
                                 output longint h, output longint s);
        if (cap == 0) begin
            c = 0; h = 0; s = 0;
        end else if (cap >= BIG) begin
            c = 16383; h = 16; s = 63;
        end else begin
            s = (cap >= 63) ? 63 : cap;
            h = ((cap / s) >= 16) ? 16 : (cap / s);
            c = cap / (h * s);
        end
    endfunction

    // Start one calculation and return the cycles until done (-1 on timeout).
    task automatic launch(input longint cap, input int mid_start_at,
                          input longint mid_cap, output int lat);
        capacity_i = cap[31:0];
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 200) begin
            if (lat == mid_start_at) begin
                capacity_i = mid_cap[31:0];
                start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        if (!done_o) lat = -1;
    endtask

    task automatic run_one(input longint cap, input int mid_start_at, input longint mid_cap);
        int lat;
        longint ec, eh, es;
        geom(cap, ec, eh, es);
        launch(cap, mid_start_at, mid_cap, lat);
        if (lat < 0) begin
            check("R6 watchdog", 0, 1);
            return;
        end
        if (cap == 0) check("R5 cyl", cyl_o, 0);
        if (cap >= BIG) check("R1 cyl", cyl_o, 16383);
        check("R2 spt", spt_o, es);
        check("R3 heads", heads_o, eh);
        check("R4 cyl", cyl_o, ec);
        if (cap == 0 || cap >= BIG) check("R6 fast latency", lat, 1);
        else check("R6 latency within 80", (lat <= 80) ? 1 : 0, 1);
        @(negedge clk);
        check("R6 done width", done_o, 0);
    endtask

    initial begin
        longint caps[$];
        longint ec, eh, es;
        repeat (3) @(negedge clk);
        check("R9 reset cyl", cyl_o, 0);
        check("R9 reset heads", heads_o, 0);
        check("R9 reset spt", spt_o, 0);
        check("R9 reset done", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after reset done", done_o, 0);

        caps = '{0, 1, 2, 62, 63, 64, 126, 1007, 1008, 1009, 1071, 5000,
                 123457, BIG - 1, BIG, BIG + 1, 32'hFFFF_FFFF, BIG - 1008};
        foreach (caps[i]) run_one(caps[i], -1, 0);
        for (int c = 1; c <= 300; c++) run_one(c, -1, 0);
        for (int c = 1000; c <= 1100; c += 7) run_one(c, -1, 0);

        // R7: a second start during a calculation is ignored.
        run_one(777, 5, 0);
        run_one(50000, 40, 99);

        // R8: outputs hold while capacity and idle cycles change.
        geom(4321, ec, eh, es);
        run_one(4321, -1, 0);
        capacity_i = 32'd5;
        repeat (10) @(negedge clk);
        check("R8 hold cyl", cyl_o, ec);
        check("R8 hold heads", heads_o, eh);
        check("R8 hold spt", spt_o, es);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule